// File: doc/BRIEF.md
# Second-Level Cache Maintenance Register Unit

This unit sits in front of a set-associative second-level cache and converts register writes into maintenance work. Software enables the cache and loads an auxiliary configuration word. It also reads an identification word, starts single-line operations by physical address, starts operations over a mask of ways, requests a drain barrier and programs per-way lockdown registers. The unit queues the work and hands it to the cache array one request at a time over a request/acknowledge pair. Software learns that the work is complete by reading back status bits.

From the auxiliary word the unit also works out the cache geometry: the number of ways, the mask of active ways and the total capacity in KB. A parameter selects the variant. The wide variant picks 16 or 8 ways with one bit. The narrow variant reads a 4-bit way count. Any other variant has 8 ways.

Top module: `l2_maint_regs`

Register offsets (12-bit byte address): 0x000 identification (read-only); 0x004 control, bit 0 is enable; 0x008 auxiliary; 0x010 drain; 0x020/0x024/0x028 line clean/invalidate/clean+invalidate; 0x030/0x034/0x038 way clean/invalidate/clean+invalidate; 0x100 + 8*i data lockdown i and 0x104 + 8*i instruction lockdown i. Array operation codes: 1 clean, 2 invalidate, 3 clean+invalidate.

## Requirements
- R1: After reset, control reads 0, auxiliary reads the parameter default, every lockdown register reads 0 and every busy bit reads 0.
- R2: A read from an unmapped offset returns 0. A write to an unmapped offset changes no readable register.
- R3: A write to auxiliary takes effect only while control bit 0 is 0. While the cache is enabled, such a write is dropped.
- R4: Wide variant: auxiliary bit 16 set gives 16 ways and clear gives 8 ways. Way size is 2^(aux[19:17]+3) KB. Capacity is ways times way size.
- R5: Narrow variant: the way count is aux[16:13], and the capacity follows the same way-size rule.
- R6: The active-way mask is (1 << ways) - 1. A way-register write keeps only the mask bits of active ways, and those bits read back as 1 right after the write.
- R7: Ways are sent to the array in ascending index order, one per acknowledge. Each bit clears when its way is acknowledged, and the array sees the operation code of the register written.
- R8: A way-register write while any way bit is still set is rejected, and err_pulse is 1 in the cycle after that write.
- R9: A write to the invalidate-way register while enabled starts no operation, and err_pulse is raised.
- R10: A line-register write sets bit 0 of the line registers until the array acknowledges that line. The array receives the written address and operation. A line write while busy is rejected with err_pulse.
- R11: Writing 0 to the drain register sets its bit 0, which stays 1 until all earlier line and way work has completed. A nonzero write is ignored.
- R12: The wide variant has 8 data/instruction lockdown pairs that can be written and read back. Offsets past the last pair read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| err_pulse | output | 1 | One-cycle flag for a rejected or illegal write |
| arr_req | output | 1 | Request to the cache array |
| arr_is_line | output | 1 | 1: line request, 0: way request |
| arr_op | output | 2 | Operation code |
| arr_way | output | 4 | Way index of a way request |
| arr_addr | output | 32 | Physical address of a line request |
| arr_ack | input | 1 | Array completed the current request |
| num_ways | output | 5 | Derived way count |
| active_mask | output | 16 | Derived active-way mask |
| size_kb | output | 20 | Derived capacity in KB |

## Verification
If the sequencer's pending state goes wrong, it appears at the array port within one request. A skipped or repeated way index, a wrong operation code or a lost address is visible right away. A status bit that never clears shows up as a register poll that times out. A wrong enable or auxiliary state shows in the derived geometry outputs in the cycle after the write. It also shows in err_pulse on the next invalidate-way write.

// File: rtl/l2m_pkg.sv
// Shared offsets, operation codes and helpers for the cache maintenance unit.
// Assumes 12-bit byte offsets and 32-bit registers.
package l2m_pkg;
    localparam int REG_AW   = 12;
    localparam int REG_DW   = 32;
    localparam int MAX_WAYS = 16;
    localparam int WAY_IW   = $clog2(MAX_WAYS);

    localparam logic [REG_AW-1:0] OFS_ID       = 12'h000;
    localparam logic [REG_AW-1:0] OFS_CTRL     = 12'h004;
    localparam logic [REG_AW-1:0] OFS_AUX      = 12'h008;
    localparam logic [REG_AW-1:0] OFS_DRAIN    = 12'h010;
    localparam logic [REG_AW-1:0] OFS_LN_CLEAN = 12'h020;
    localparam logic [REG_AW-1:0] OFS_LN_INV   = 12'h024;
    localparam logic [REG_AW-1:0] OFS_LN_CLINV = 12'h028;
    localparam logic [REG_AW-1:0] OFS_WY_CLEAN = 12'h030;
    localparam logic [REG_AW-1:0] OFS_WY_INV   = 12'h034;
    localparam logic [REG_AW-1:0] OFS_WY_CLINV = 12'h038;
    localparam logic [REG_AW-1:0] OFS_LOCK     = 12'h100;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_INV   = 2'd2,
        OP_CLINV = 2'd3
    } maint_op_e;

    // Operation selected by the low nibble of a line or way offset.
    function automatic maint_op_e op_of(input logic [REG_AW-1:0] a);
        case (a[3:0])
            4'h0:    op_of = OP_CLEAN;
            4'h4:    op_of = OP_INV;
            4'h8:    op_of = OP_CLINV;
            default: op_of = OP_NONE;
        endcase
    endfunction
endpackage

// File: rtl/l2m_geom.sv
// Derives way count, active-way mask and capacity from the auxiliary word.
// PART_TYPE: 0 = wide variant (bit 16 picks 16/8), 1 = narrow variant
// (bits 16:13 hold the count), other values = fixed 8 ways.
module l2m_geom #(
    parameter int PART_TYPE = 0
) (
    input  logic [l2m_pkg::REG_DW-1:0]   aux,
    output logic [4:0]                   num_ways,
    output logic [l2m_pkg::MAX_WAYS-1:0] active_mask,
    output logic [19:0]                  size_kb
);
    localparam int MW = l2m_pkg::MAX_WAYS;

    logic [2:0]  wsz_field;
    logic [10:0] way_kb;

    // Way count chosen by the variant.
    generate
        if (PART_TYPE == 0) begin : g_wide
            assign num_ways = aux[16] ? 5'd16 : 5'd8;
        end else if (PART_TYPE == 1) begin : g_narrow
            assign num_ways = {1'b0, aux[16:13]};
        end else begin : g_other
            assign num_ways = 5'd8;
        end
    endgenerate

    // Way size in KB and capacity.
    always_comb begin
        wsz_field = aux[19:17];
        way_kb    = 11'd8 << wsz_field;
        size_kb   = 20'(num_ways) * 20'(way_kb);
    end

    // Mask of the ways that exist.
    always_comb begin
        for (int i = 0; i < MW; i++) begin
            active_mask[i] = (i < int'(num_ways));
        end
    end
endmodule

// File: rtl/l2m_lockdown.sv
// Bank of data/instruction lockdown register pairs with 8-byte stride.
// Assumes the top gates writes; reset clears every register.
module l2m_lockdown #(
    parameter int PAIRS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [l2m_pkg::REG_AW-1:0]  addr,
    input  logic [l2m_pkg::REG_DW-1:0]  wdata,
    output logic                        hit,
    output logic [l2m_pkg::REG_DW-1:0]  rdata
);
    import l2m_pkg::*;
    localparam int SPAN = 8 * PAIRS;

    logic [REG_AW-1:0] rel;
    logic [REG_DW-1:0] dreg [PAIRS];
    logic [REG_DW-1:0] ireg [PAIRS];

    // Region decode relative to the bank base.
    always_comb begin
        rel = addr - OFS_LOCK;
        hit = (addr >= OFS_LOCK) && (int'(rel) < SPAN) && (rel[1:0] == 2'b00);
    end

    generate
        for (genvar k = 0; k < PAIRS; k++) begin : g_pair
            // Holds pair k; written when its offset is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dreg[k] <= '0;
                    ireg[k] <= '0;
                end else if (we && hit && int'(rel[REG_AW-1:3]) == k) begin
                    if (rel[2]) ireg[k] <= wdata;
                    else        dreg[k] <= wdata;
                end
            end
        end
    endgenerate

    // Read-back mux.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < PAIRS; k++) begin
            if (hit && int'(rel[REG_AW-1:3]) == k) rdata = rel[2] ? ireg[k] : dreg[k];
        end
    end
endmodule

// File: rtl/l2m_engine.sv
// Maintenance sequencer: holds one line request and a way mask, issues them
// to the array one at a time (line first, then lowest way), tracks the drain.
// Assumes line_start only when idle on lines and way_start only when no
// way bit is pending.
module l2m_engine (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_start,
    input  l2m_pkg::maint_op_e            line_op,
    input  logic [l2m_pkg::REG_DW-1:0]    line_addr,
    input  logic                          way_start,
    input  l2m_pkg::maint_op_e            way_op,
    input  logic [l2m_pkg::MAX_WAYS-1:0]  way_mask,
    input  logic                          drain_start,
    input  logic                          arr_ack,
    output logic                          line_busy,
    output logic [l2m_pkg::MAX_WAYS-1:0]  way_pend,
    output logic                          drain_busy,
    output logic                          arr_req,
    output logic                          arr_is_line,
    output l2m_pkg::maint_op_e            arr_op,
    output logic [l2m_pkg::WAY_IW-1:0]    arr_way,
    output logic [l2m_pkg::REG_DW-1:0]    arr_addr
);
    import l2m_pkg::*;

    maint_op_e         line_op_q, way_op_q;
    logic [WAY_IW-1:0] low_idx;
    logic              all_idle;

    // Lowest pending way index.
    always_comb begin
        low_idx = '0;
        for (int i = MAX_WAYS - 1; i >= 0; i--) begin
            if (way_pend[i]) low_idx = WAY_IW'(i);
        end
        all_idle = !line_busy && (way_pend == '0) && !arr_req;
    end

    // Pending work, request issue and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_pend    <= '0;
            line_busy   <= 1'b0;
            arr_req     <= 1'b0;
            arr_is_line <= 1'b0;
            arr_way     <= '0;
            arr_addr    <= '0;
            line_op_q   <= OP_NONE;
            way_op_q    <= OP_NONE;
        end else begin
            if (way_start) begin
                way_pend <= way_mask;
                way_op_q <= way_op;
            end
            if (line_start) begin
                line_busy <= 1'b1;
                line_op_q <= line_op;
                arr_addr  <= line_addr;
            end
            if (arr_req) begin
                if (arr_ack) begin
                    arr_req <= 1'b0;
                    if (arr_is_line) line_busy <= 1'b0;
                    else             way_pend[arr_way] <= 1'b0;
                end
            end else if (line_busy) begin
                arr_req     <= 1'b1;
                arr_is_line <= 1'b1;
            end else if (way_pend != '0) begin
                arr_req     <= 1'b1;
                arr_is_line <= 1'b0;
                arr_way     <= low_idx;
            end
        end
    end

    // Drain flag: set by request, cleared once no earlier work remains.
    always_ff @(posedge clk) begin
        if (!rst_n)           drain_busy <= 1'b0;
        else if (drain_start) drain_busy <= 1'b1;
        else if (all_idle)    drain_busy <= 1'b0;
    end

    assign arr_op = arr_is_line ? line_op_q : way_op_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_ack |=> arr_req && $stable(arr_way) && $stable(arr_is_line)); // R7
    AST_WAY_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_is_line |-> (way_pend & ((16'd1 << arr_way) - 16'd1)) == '0); // R7
    AST_PEND_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        !way_start |=> (way_pend & ~$past(way_pend)) == '0); // R7
    AST_LINE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && arr_is_line |-> line_busy); // R10
    AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drain_busy) |-> $past(!line_busy && way_pend == '0)); // R11
endmodule

// File: rtl/l2_maint_regs.sv
// Register front end of the cache maintenance unit: decodes writes, guards
// configuration while enabled, rejects overlapping requests and muxes reads.
// Assumes single-cycle write strobes; reads are combinational.
module l2_maint_regs #(
    parameter int          PART_TYPE = 0,
    parameter logic [31:0] AUX_RESET = 32'h0002_0000,
    parameter logic [31:0] ID_WORD   = 32'h0000_0300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        err_pulse,
    output logic        arr_req,
    output logic        arr_is_line,
    output logic [1:0]  arr_op,
    output logic [3:0]  arr_way,
    output logic [31:0] arr_addr,
    input  logic        arr_ack,
    output logic [4:0]  num_ways,
    output logic [15:0] active_mask,
    output logic [19:0] size_kb
);
    import l2m_pkg::*;
    localparam int LOCK_PAIRS = (PART_TYPE == 0) ? 8 : 1;

    logic              ctrl_en;
    logic [REG_DW-1:0] aux_q;
    logic              is_line, is_way, bad_wr;
    logic              line_start, way_start, drain_start;
    logic              line_busy, drain_busy;
    logic [MAX_WAYS-1:0] way_pend;
    maint_op_e         wr_op, arr_op_e;
    logic              lk_hit;
    logic [REG_DW-1:0] lk_rdata;

    // Classify the current write and decide whether it is accepted.
    always_comb begin
        wr_op       = op_of(reg_addr);
        is_line     = reg_we && (reg_addr[11:4] == OFS_LN_CLEAN[11:4]) && wr_op != OP_NONE;
        is_way      = reg_we && (reg_addr[11:4] == OFS_WY_CLEAN[11:4]) && wr_op != OP_NONE;
        bad_wr      = (is_line && line_busy)
                    || (is_way && (way_pend != '0))
                    || (is_way && wr_op == OP_INV && ctrl_en);
        line_start  = is_line && !line_busy;
        way_start   = is_way && !bad_wr;
        drain_start = reg_we && reg_addr == OFS_DRAIN && reg_wdata == '0;
    end

    // Control and auxiliary registers; auxiliary frozen while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            aux_q   <= AUX_RESET;
        end else if (reg_we) begin
            if (reg_addr == OFS_CTRL)             ctrl_en <= reg_wdata[0];
            if (reg_addr == OFS_AUX && !ctrl_en)  aux_q   <= reg_wdata;
        end
    end

    // One-cycle error flag for rejected or illegal writes.
    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= bad_wr;
    end

    l2m_geom #(.PART_TYPE(PART_TYPE)) u_geom (
        .aux(aux_q), .num_ways(num_ways), .active_mask(active_mask), .size_kb(size_kb)
    );

    l2m_lockdown #(.PAIRS(LOCK_PAIRS)) u_lock (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .hit(lk_hit), .rdata(lk_rdata)
    );

    l2m_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .line_start(line_start), .line_op(wr_op), .line_addr(reg_wdata),
        .way_start(way_start), .way_op(wr_op), .way_mask(reg_wdata[MAX_WAYS-1:0] & active_mask),
        .drain_start(drain_start), .arr_ack(arr_ack),
        .line_busy(line_busy), .way_pend(way_pend), .drain_busy(drain_busy),
        .arr_req(arr_req), .arr_is_line(arr_is_line), .arr_op(arr_op_e),
        .arr_way(arr_way), .arr_addr(arr_addr)
    );
    assign arr_op = arr_op_e;

    // Read mux; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ID:       reg_rdata = ID_WORD;
            OFS_CTRL:     reg_rdata = {31'b0, ctrl_en};
            OFS_AUX:      reg_rdata = aux_q;
            OFS_DRAIN:    reg_rdata = {31'b0, drain_busy};
            OFS_LN_CLEAN, OFS_LN_INV, OFS_LN_CLINV: reg_rdata = {31'b0, line_busy};
            OFS_WY_CLEAN, OFS_WY_INV, OFS_WY_CLINV: reg_rdata = {16'b0, way_pend};
            default:      reg_rdata = lk_hit ? lk_rdata : '0;
        endcase
    end

    AST_AUX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en |=> $stable(aux_q)); // R3
    AST_INV_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == OFS_WY_INV && ctrl_en |=> err_pulse); // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == OFS_WY_CLEAN && way_pend != '0 |=> err_pulse); // R8
    AST_PEND_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (way_pend & ~active_mask) == '0 || $past(aux_q) != aux_q); // R6
endmodule

// File: tb/tb_l2_maint_regs.sv
`timescale 1ns/1ps
module tb_l2_maint_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        we = 1'b0, nwe = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, nrdata;
    logic        err, nerr;
    logic        arr_req, arr_is_line, arr_ack = 1'b0;
    logic [1:0]  arr_op;
    logic [3:0]  arr_way;
    logic [31:0] arr_addr;
    logic [4:0]  ways, nways;
    logic [15:0] amask, namask;
    logic [19:0] kb, nkb;
    logic        n_req, n_line;
    logic [1:0]  n_op;
    logic [3:0]  n_way;
    logic [31:0] n_addr;

    l2_maint_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .err_pulse(err), .arr_req(arr_req), .arr_is_line(arr_is_line),
        .arr_op(arr_op), .arr_way(arr_way), .arr_addr(arr_addr), .arr_ack(arr_ack),
        .num_ways(ways), .active_mask(amask), .size_kb(kb));

    l2_maint_regs #(.PART_TYPE(1), .AUX_RESET(32'h0)) dut_n (
        .clk(clk), .rst_n(rst_n), .reg_we(nwe), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(nrdata), .err_pulse(nerr), .arr_req(n_req), .arr_is_line(n_line),
        .arr_op(n_op), .arr_way(n_way), .arr_addr(n_addr), .arr_ack(1'b0),
        .num_ways(nways), .active_mask(namask), .size_kb(nkb));

    int nvec = 0, nfail = 0;

    // Array model: acknowledges after the request has been up three cycles.
    logic [1:0] acnt = '0;
    always @(posedge clk) begin
        if (!arr_req || arr_ack) begin acnt <= '0; arr_ack <= 1'b0; end
        else if (acnt == 2'd2) arr_ack <= 1'b1;
        else acnt <= acnt + 2'd1;
    end

    // Log of completed array requests.
    int         log_n = 0;
    logic [3:0] log_way [32];
    logic       log_line[32];
    logic [1:0] log_op  [32];
    logic [31:0] log_addr[32];
    always @(posedge clk) begin
        if (arr_req && arr_ack && log_n < 32) begin
            log_way[log_n]  <= arr_way;
            log_line[log_n] <= arr_is_line;
            log_op[log_n]   <= arr_op;
            log_addr[log_n] <= arr_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    logic last_err;
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; last_err = err; we = 1'b0;
    endtask
    task automatic wr_n(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); nwe = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; nwe = 1'b0;
    endtask
    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask
    task automatic poll_clear(input string req, input logic [11:0] a);
        logic [31:0] v;
        int n = 0;
        rd(a, v);
        while (v != 0 && n < 200) begin rd(a, v); n++; end
        check(req, v, 32'h0);
    endtask

    typedef struct packed {
        logic        w;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;
    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{1'b0, 12'h004, 32'h0,         32'h0},          // R1 control
        '{1'b0, 12'h008, 32'h0,         32'h0002_0000},  // R1 aux default
        '{1'b0, 12'h108, 32'h0,         32'h0},          // R1 lockdown
        '{1'b0, 12'h000, 32'h0,         32'h0000_0300},  // R1 id
        '{1'b1, 12'h0FC, 32'hDEAD_BEEF, 32'h0},          // R2 unmapped
        '{1'b1, 12'h008, 32'h0005_0000, 32'h0005_0000},  // R3 aux while off
        '{1'b1, 12'h118, 32'h0000_00FF, 32'h0000_00FF},  // R12 data pair 3
        '{1'b1, 12'h13C, 32'h0000_000F, 32'h0000_000F},  // R12 instr pair 7
        '{1'b1, 12'h140, 32'h1234_5678, 32'h0},          // R12 past last pair
        '{1'b1, 12'h004, 32'h1,         32'h1},          // enable
        '{1'b1, 12'h008, 32'h0,         32'h0005_0000},  // R3 aux frozen
        '{1'b1, 12'h004, 32'h0,         32'h0}           // disable
    };

    initial begin
        #(4 * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: optional write then read-back.
        for (int i = 0; i < NV; i++) begin
            if (VT[i].w) wr(VT[i].a, VT[i].d);
            rd(VT[i].a, v);
            check($sformatf("R1/R2/R3/R12 vector %0d", i), v, VT[i].e);
        end
        rd(12'h024, v); check("R1 line idle", v, 0);
        rd(12'h030, v); check("R1 way idle", v, 0);
        rd(12'h0FC, v); check("R2 unmapped still zero", v, 0);

        // R4: wide variant geometry, aux 0x0005_0000 -> 16 ways x 32 KB.
        check("R4 ways 16", 32'(ways), 16);
        check("R4 size 512KB", 32'(kb), 512);
        check("R6 mask 16", 32'(amask), 32'hFFFF);
        wr(12'h008, 32'h0002_0000);
        check("R4 ways 8", 32'(ways), 8);
        check("R4 size 128KB", 32'(kb), 128);
        check("R6 mask 8", 32'(amask), 32'h00FF);

        // R5: narrow variant, count 4 in bits 16:13, field 0 -> 8 KB.
        wr_n(12'h008, 32'h0000_8000);
        check("R5 ways 4", 32'(nways), 4);
        check("R5 size 32KB", 32'(nkb), 32);
        check("R6 narrow mask", 32'(namask), 32'h000F);

        // R6/R7/R8: way clean on ways 0,2,5,7 plus inactive bit 9.
        @(negedge clk); log_n = 0;
        wr(12'h030, 32'h0000_02A5);
        rd(12'h030, v); check("R6 way readback", v, 32'h0000_00A5);
        wr(12'h030, 32'h0000_0001);
        check("R8 err on busy way write", 32'(last_err), 1);
        poll_clear("R7 way bits clear", 12'h030);
        repeat (2) @(posedge clk); #1;
        check("R7 way count", 32'(log_n), 4);
        check("R7 order 0", 32'(log_way[0]), 0);
        check("R7 order 1", 32'(log_way[1]), 2);
        check("R7 order 2", 32'(log_way[2]), 5);
        check("R7 order 3", 32'(log_way[3]), 7);
        check("R7 op clean", 32'(log_op[0]), 1);
        check("R7 way not line", 32'(log_line[3]), 0);

        // R9: invalidate-way while enabled.
        wr(12'h004, 32'h1);
        @(negedge clk); log_n = 0;
        wr(12'h034, 32'h0000_00FF);
        check("R9 err", 32'(last_err), 1);
        rd(12'h034, v); check("R9 no pending", v, 0);
        repeat (8) @(posedge clk); #1;
        check("R9 no array request", 32'(log_n), 0);
        wr(12'h004, 32'h0);

        // R10: line invalidate by address.
        @(negedge clk); log_n = 0;
        wr(12'h024, 32'h1234_5660);
        rd(12'h024, v); check("R10 line busy", v, 1);
        wr(12'h028, 32'h0000_0040);
        check("R10 err on busy line write", 32'(last_err), 1);
        poll_clear("R10 line done", 12'h024);
        repeat (2) @(posedge clk); #1;
        check("R10 one request", 32'(log_n), 1);
        check("R10 address", log_addr[0], 32'h1234_5660);
        check("R10 op inv", 32'(log_op[0]), 2);
        check("R10 is line", 32'(log_line[0]), 1);

        // R11: drain waits for earlier line work.
        wr(12'h020, 32'h0000_1000);
        wr(12'h010, 32'h0);
        rd(12'h010, v); check("R11 drain busy", v, 1);
        rd(12'h020, v); check("R11 line still busy", v, 1);
        poll_clear("R11 drain clears", 12'h010);
        rd(12'h020, v); check("R11 line done before drain", v, 0);
        wr(12'h010, 32'h5);
        rd(12'h010, v); check("R11 nonzero ignored", v, 0);

        // R1: reset again restores defaults.
        wr(12'h008, 32'h000F_0000);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; @(negedge clk); rst_n = 1'b1;
        rd(12'h008, v); check("R1 aux after reset", v, 32'h0002_0000);
        rd(12'h118, v); check("R1 lockdown after reset", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule